// File: doc/BRIEF.md
# NAND Page Read Sequencer

This block is the read path inside a byte-wide NAND flash device. It watches the command latch, address latch, chip enable, write strobe and read strobe pins, all sampled by the core clock. From these it decodes read opcodes into a three-way area pointer: first half of the main area, second half of the main area, or the spare bytes. It gathers a four-cycle address and loads the addressed page into an internal page buffer. While the load runs, it holds the ready/busy pin low. After the load, it hands out one byte for each falling edge of the read strobe.

A page has 512 main bytes and 16 spare bytes. When a read passes the last column of its area, the block moves to the next row on its own, loads that page and carries on. The sequence ends when the chip enable is driven high. The array fill is modelled as a fixed-latency load. Every byte written into the buffer is a known function of its row and column, so a host can check every byte it reads.

Top module: `nand_rd_seq`

## Requirements
- R1: After reset, rb_no is 1, dout_o is 8'h00, and the pointer selects the first half of the main area.
- R2: A byte is taken as a command on a rising edge of we_ni seen with cle_i=1, ale_i=0 and ce_ni=0. 8'h00 selects the first half, 8'h01 the second half and 8'h50 the spare area. Any other byte, or a strobe with ce_ni=1, leaves the pointer unchanged.
- R3: Address bytes are taken on rising edges of we_ni with ale_i=1, cle_i=0 and ce_ni=0. The order is column byte A, then three row bytes with the least significant byte first. The row is the low 18 bits of those three bytes. The fourth byte starts a page load. A command resets the byte count.
- R4: Each page load holds rb_no at 0 for exactly T_LOAD clock cycles, starting the cycle after the event that starts the load.
- R5: Byte c of the page in row r holds r[7:0] ^ c[7:0] ^ {c[9:8],6'b0}. While ready, a rising clock edge that finds re_ni low after it was high puts the byte at the current column on dout_o and advances the column.
- R6: The start column is A for the first half, 256+A for the second half, and 512+A[3:0] for the spare area. A[7:4] is ignored in spare mode.
- R7: A second-half pointer returns to the first half once the fourth address byte of a read has been taken.
- R8: The spare pointer stays in effect across reads. Only 8'h00 or 8'h01 moves it back to the main area.
- R9: A read from the main area ends at column 511; a read from the spare area ends at column 527. After the last byte, the next row loads (R4) and output resumes at column 0 (main) or column 512 (spare).
- R10: The row after 2^18-1 is row 0.
- R11: ce_ni=1 ends a sequential read. Later read strobes leave dout_o unchanged until a new address sequence completes.
- R12: Read strobes while rb_no is 0 are ignored, and the column does not advance.
- R13: The last read command stays in effect, so a read made of address bytes alone uses the current pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cle_i | input | 1 | Command latch enable |
| ale_i | input | 1 | Address latch enable |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write strobe, active low, data taken on rising edge |
| re_ni | input | 1 | Read strobe, active low, byte produced on falling edge |
| io_i | input | 8 | Command and address bus |
| dout_o | output | 8 | Read data |
| rb_no | output | 1 | Ready (1) or busy (0) |

## Verification
The hardest state to reach is the automatic row rollover, and above all its meeting with the row wrap and the spare area. Only a read that ends exactly on the last column of an area triggers it. The stimulus places the start column two bytes before the end of the spare area and of the main area. It uses an all-ones row for the main-area case, then reads past the boundary, waits out the second load, and checks the bytes of the following row. Second-half snap-back and spare persistence are reached by reads that use address bytes alone, or an unknown opcode, right after the command under test.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;

  typedef enum logic [1:0] {
    AREA_H0 = 2'd0,
    AREA_H1 = 2'd1,
    AREA_SP = 2'd2
  } area_e;

  localparam logic [7:0] OP_RD_H0 = 8'h00;
  localparam logic [7:0] OP_RD_H1 = 8'h01;
  localparam logic [7:0] OP_RD_SP = 8'h50;

  // modelled array content
  function automatic logic [7:0] page_byte(input logic [23:0] row, input logic [15:0] col);
    return row[7:0] ^ col[7:0] ^ {col[9:8], 6'd0};
  endfunction

endpackage

// File: rtl/nand_strobe_edge.sv
module nand_strobe_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic edge_o
);

  logic pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b1;
    else         pin_q <= pin_i;
  end

  generate
    if (RISING) begin : g_rise
      assign edge_o = pin_i & ~pin_q;
    end else begin : g_fall
      assign edge_o = ~pin_i & pin_q;
    end
  endgenerate

endmodule

// File: rtl/nand_page_buf.sv
module nand_page_buf
  import nand_rd_pkg::*;
#(
  parameter int PAGE_BYTES = 528,
  parameter int T_LOAD     = 600,
  parameter int ROW_W      = 18,
  parameter int COL_W      = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] rd_addr_i,
  output logic [7:0]       rd_data_o,
  output logic             busy_o
);

  localparam int CNT_W = $clog2(T_LOAD + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(T_LOAD - 1);
  localparam logic [CNT_W-1:0] FILL_END = CNT_W'(PAGE_BYTES);

  logic [7:0]       mem [PAGE_BYTES];
  logic [CNT_W-1:0] cnt_q;
  logic [ROW_W-1:0] row_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      row_q  <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      row_q  <= row_i;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) busy_q <= 1'b0;
    end
  end

  // one byte per cycle during the load window
  always_ff @(posedge clk_i) begin
    if (busy_q && cnt_q < FILL_END)
      mem[COL_W'(cnt_q)] <= page_byte(24'(row_q), 16'(cnt_q));
  end

  assign rd_data_o = mem[rd_addr_i];
  assign busy_o    = busy_q;

endmodule

// File: rtl/nand_rd_seq.sv
module nand_rd_seq
  import nand_rd_pkg::*;
#(
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int ROW_W       = 18,
  parameter int T_LOAD      = 600
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic       ce_ni,
  input  logic       we_ni,
  input  logic       re_ni,
  input  logic [7:0] io_i,
  output logic [7:0] dout_o,
  output logic       rb_no
);

  localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES;
  localparam int COL_W      = $clog2(PAGE_BYTES);
  localparam int SP_W       = $clog2(SPARE_BYTES);
  localparam logic [COL_W-1:0] MAIN_LAST = COL_W'(MAIN_BYTES - 1);
  localparam logic [COL_W-1:0] PAGE_LAST = COL_W'(PAGE_BYTES - 1);
  localparam logic [COL_W-1:0] HALF_BASE = COL_W'(MAIN_BYTES / 2);
  localparam logic [COL_W-1:0] SP_BASE   = COL_W'(MAIN_BYTES);

  logic we_rise, re_fall, busy;
  logic cmd_stb, addr_stb, addr_done, rd_stb, at_end, load_start;
  logic [1:0]       acnt_q;
  logic [7:0]       a_col_q;
  logic [15:0]      a_row_q;
  logic [ROW_W-1:0] row_new, row_q, load_row;
  logic [COL_W-1:0] col_q, start_col, last_col, rd_data_col;
  logic [7:0]       rd_data, dout_q;
  logic             reading_q;
  area_e            ptr_q;

  nand_strobe_edge #(.RISING(1'b1)) u_we_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(we_ni), .edge_o(we_rise)
  );
  nand_strobe_edge #(.RISING(1'b0)) u_re_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(re_ni), .edge_o(re_fall)
  );

  assign cmd_stb   = we_rise & cle_i & ~ale_i & ~ce_ni & ~busy;
  assign addr_stb  = we_rise & ale_i & ~cle_i & ~ce_ni & ~busy;
  assign addr_done = addr_stb & (acnt_q == 2'd3);
  assign row_new   = ROW_W'({io_i, a_row_q});

  // address byte collection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acnt_q  <= '0;
      a_col_q <= '0;
      a_row_q <= '0;
    end else if (cmd_stb) begin
      acnt_q <= '0;
    end else if (addr_stb) begin
      acnt_q <= acnt_q + 1'b1;
      case (acnt_q)
        2'd0:    a_col_q        <= io_i;
        2'd1:    a_row_q[7:0]   <= io_i;
        2'd2:    a_row_q[15:8]  <= io_i;
        default: ;
      endcase
    end
  end

  // area pointer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= AREA_H0;
    end else if (cmd_stb) begin
      case (io_i)
        OP_RD_H0: ptr_q <= AREA_H0;
        OP_RD_H1: ptr_q <= AREA_H1;
        OP_RD_SP: ptr_q <= AREA_SP;
        default:  ;
      endcase
    end else if (addr_done && ptr_q == AREA_H1) begin
      ptr_q <= AREA_H0;
    end
  end

  always_comb begin
    case (ptr_q)
      AREA_H1: start_col = HALF_BASE + COL_W'(a_col_q);
      AREA_SP: start_col = SP_BASE + COL_W'(a_col_q[SP_W-1:0]);
      default: start_col = COL_W'(a_col_q);
    endcase
  end

  assign last_col    = (col_q >= SP_BASE) ? PAGE_LAST : MAIN_LAST;
  assign at_end      = (col_q == last_col);
  assign rd_stb      = re_fall & ~ce_ni & reading_q & ~busy;
  assign load_start  = addr_done | (rd_stb & at_end);
  assign load_row    = addr_done ? row_new : row_q + 1'b1;
  assign rd_data_col = col_q;

  // column / row sequencing and output register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reading_q <= 1'b0;
      col_q     <= '0;
      row_q     <= '0;
      dout_q    <= '0;
    end else if (addr_done) begin
      reading_q <= 1'b1;
      col_q     <= start_col;
      row_q     <= row_new;
    end else if (ce_ni) begin
      reading_q <= 1'b0;
    end else if (rd_stb) begin
      dout_q <= rd_data;
      if (at_end) begin
        row_q <= row_q + 1'b1;
        col_q <= (col_q >= SP_BASE) ? SP_BASE : '0;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  nand_page_buf #(
    .PAGE_BYTES(PAGE_BYTES),
    .T_LOAD    (T_LOAD),
    .ROW_W     (ROW_W),
    .COL_W     (COL_W)
  ) u_buf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_start),
    .row_i    (load_row),
    .rd_addr_i(rd_data_col),
    .rd_data_o(rd_data),
    .busy_o   (busy)
  );

  assign dout_o = dout_q;
  assign rb_no  = ~busy;

endmodule

// File: rtl/nand_rd_seq_chk.sv
module nand_rd_seq_chk #(
  parameter int T_LOAD = 600,
  parameter int COL_W  = 10,
  parameter int PAGE_BYTES = 528
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce_ni,
  input logic             rb_no,
  input logic [7:0]       dout_o,
  input logic [1:0]       ptr_i,
  input logic             addr_done_i,
  input logic [COL_W-1:0] col_i
);

  int busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= 0;
    else if (!rb_no) busy_cnt <= busy_cnt + 1;
    else             busy_cnt <= 0;
  end

  // R4
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rb_no) |-> busy_cnt == T_LOAD);

  // R12
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rb_no |=> $stable(dout_o));

  // R11
  ce_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> $stable(dout_o));

  // R7
  snap_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_done_i && ptr_i == 2'd1) |=> ptr_i == 2'd0);

  // R9
  col_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(col_i) < PAGE_BYTES);

endmodule

bind nand_rd_seq nand_rd_seq_chk #(
  .T_LOAD    (T_LOAD),
  .COL_W     (COL_W),
  .PAGE_BYTES(PAGE_BYTES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_ni      (ce_ni),
  .rb_no      (rb_no),
  .dout_o     (dout_o),
  .ptr_i      (ptr_q),
  .addr_done_i(addr_done),
  .col_i      (col_q)
);

// File: tb/nand_rd_seq_tb.sv
module nand_rd_seq_tb;

  localparam int T_LOAD = 600;
  localparam logic [17:0] ROW_MASK = 18'h3FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cle = 1'b0, ale = 1'b0, ce_n = 1'b0, we_n = 1'b1, re_n = 1'b1;
  logic [7:0] io = 8'h00;
  logic [7:0] dout;
  logic rb_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  nand_rd_seq #(.T_LOAD(T_LOAD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cle_i(cle), .ale_i(ale), .ce_ni(ce_n),
    .we_ni(we_n), .re_ni(re_n), .io_i(io), .dout_o(dout), .rb_no(rb_n)
  );

  typedef struct packed {
    logic [7:0]  cmd;
    logic [7:0]  col;
    logic [23:0] row;
    logic [15:0] nrd;
    logic [15:0] exp_col;
  } vec_t;

  // cmd 8'hFF / 8'hAA are unknown opcodes: pointer must not move
  localparam vec_t VECS [8] = '{
    '{8'h00, 8'h05, 24'h000010, 16'd4, 16'd5},    // R6 first half
    '{8'h01, 8'h03, 24'h000020, 16'd3, 16'd259},  // R6 second half
    '{8'hFF, 8'h03, 24'h000030, 16'd2, 16'd3},    // R7 R2 snap back
    '{8'h50, 8'hF5, 24'h000040, 16'd3, 16'd517},  // R6 spare, A[7:4] ignored
    '{8'hAA, 8'h02, 24'h000041, 16'd2, 16'd514},  // R8 spare persists
    '{8'h00, 8'h00, 24'h000050, 16'd2, 16'd0},    // R8 back to main
    '{8'h50, 8'h0E, 24'h000060, 16'd5, 16'd526},  // R9 spare rollover
    '{8'h01, 8'hFE, 24'hFFFFFF, 16'd4, 16'd510}   // R9 R10 main rollover, row wrap
  };

  function automatic logic [7:0] exp_byte(input logic [17:0] r, input int c);
    logic [9:0] cc;
    cc = 10'(c);
    return r[7:0] ^ cc[7:0] ^ {cc[9:8], 6'd0};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic we_cycle(input logic c, input logic a, input logic [7:0] d);
    @(negedge clk); cle = c; ale = a; io = d; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); cle = 1'b0; ale = 1'b0;
  endtask

  task automatic send_addr(input logic [7:0] col, input logic [23:0] row);
    we_cycle(1'b0, 1'b1, col);
    we_cycle(1'b0, 1'b1, row[7:0]);
    we_cycle(1'b0, 1'b1, row[15:8]);
    we_cycle(1'b0, 1'b1, row[23:16]);
  endtask

  task automatic re_pulse(output logic [7:0] d);
    @(negedge clk); re_n = 1'b0;
    @(negedge clk); re_n = 1'b1;
    d = dout;
  endtask

  task automatic wait_ready(output int lows);
    lows = 0;
    while (rb_n == 1'b0 && lows < 2 * T_LOAD + 10) begin
      lows++;
      @(negedge clk);
    end
  endtask

  task automatic read_run(input string req, input logic [17:0] row, input int col, input int nrd);
    logic [17:0] r;
    int c, lows;
    logic [7:0] got;
    r = row;
    c = col;
    for (int k = 0; k < nrd; k++) begin
      re_pulse(got);
      check(req, int'(got), int'(exp_byte(r, c)));
      if (c == 511 || c == 527) begin
        c = (c == 527) ? 512 : 0;
        r = (r + 18'd1) & ROW_MASK;
        wait_ready(lows);
        check("R9 R4 rollover load", lows, T_LOAD);
      end else begin
        c++;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int lows;
    logic [7:0] got, prev;

    repeat (3) @(negedge clk);
    check("R1 rb_no reset", int'(rb_n), 1);
    check("R1 dout reset", int'(dout), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R13: default pointer, address-only read
    send_addr(8'h07, 24'h000005);
    wait_ready(lows);
    check("R4 load length", lows, T_LOAD);
    read_run("R1 R13 default first half", 18'h5, 7, 2);

    // R2: command with CE# high ignored
    we_cycle(1'b1, 1'b0, 8'h00);
    ce_n = 1'b1;
    we_cycle(1'b1, 1'b0, 8'h50);
    ce_n = 1'b0;
    send_addr(8'h09, 24'h000006);
    wait_ready(lows);
    read_run("R2 CE# high command ignored", 18'h6, 9, 1);

    // R12: read strobe during busy ignored
    prev = dout;
    send_addr(8'h11, 24'h000007);
    re_pulse(got);
    check("R12 dout during busy", int'(got), int'(prev));
    wait_ready(lows);
    read_run("R12 column not advanced", 18'h7, 17, 1);

    // R11: CE# high ends sequence
    prev = dout;
    ce_n = 1'b1;
    re_pulse(got);
    check("R11 CE# high", int'(got), int'(prev));
    ce_n = 1'b0;
    re_pulse(got);
    check("R11 after CE# low again", int'(got), int'(prev));
    check("R11 no load", int'(rb_n), 1);

    // R3 R5 R6 R7 R8 R9 R10: vector table
    for (int i = 0; i < 8; i++) begin
      we_cycle(1'b1, 1'b0, VECS[i].cmd);
      send_addr(VECS[i].col, VECS[i].row);
      wait_ready(lows);
      check("R4 R3 load length", lows, T_LOAD);
      read_run("R5 R6 table read", 18'(VECS[i].row), int'(VECS[i].exp_col), int'(VECS[i].nrd));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule